// File: doc/BRIEF.md
# Word-Addressed Load/Store Access Unit

This unit sits between the execute and align stages of a 32-bit integer core and the data-memory bus. In the execute stage it takes an access command (load or store, access size, sign or zero extension, byte address and store data). It turns the byte address into a word address for the bus and drives the lane byte enables and lane-replicated store data. It also checks the access: a halfword or word access that is not naturally aligned is refused, and so is any address beyond the configured word-address space. A refused access never reaches the bus.

The bus may have any latency. While the bus holds its wait line high, the unit keeps its request on the bus and raises a stall output. After a read has been accepted, the unit records the lane offset and extension mode. It keeps the stall output high until the bus returns data with its valid strobe. The align stage then selects the addressed lane from the returned word and extends it to 32 bits.

Top module: `lsu_mem_port`

## Requirements
- R1: The bus address is the word address, byte address bits [ADDR_W+1:2]. Byte address bits [1:0] never appear on the bus. The read and write strobes are never high together.
- R2: Access size codes: 00 byte, 01 halfword, 10 word, 11 treated as word. A byte store enables lane 0001 shifted left by byte address bits [1:0]. A halfword store enables 0011 at offset 0 or 1100 at offset 2. A word store enables 1111.
- R3: The byte store data is the low byte copied into all four lanes. The halfword store data is the low halfword copied into both halves. The word store data is passed unchanged.
- R4: A halfword access with address bit 0 set, or a word access with either of address bits [1:0] set, raises fault_misaligned. It drives neither bus strobe.
- R5: An access whose byte address bits [31:ADDR_W+2] are not all zero raises fault_access and drives neither bus strobe. When both faults apply, only fault_misaligned is raised. Byte accesses are never misaligned.
- R6: While bus_wait is high, a non-faulting request stays on the bus and ex_busy is high.
- R7: After a read is accepted (bus_read high, bus_wait low at a clock edge), ex_busy stays high until bus_rvalid. In the cycle bus_rvalid is high, ld_valid is high and ex_busy is low.
- R8: Signed byte and halfword loads (ex_zext low) sign-extend the lane chosen by the captured offset. A word load returns the bus word unchanged.
- R9: Byte and halfword loads with ex_zext high zero-extend the selected lane.
- R10: After reset, with no request, ex_busy, ld_valid, both strobes and both faults are low.
- R11: bus_rvalid while no read is outstanding has no effect: ld_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Access command present in execute stage |
| ex_store | input | 1 | 1 store, 0 load |
| ex_size | input | 2 | Access size code |
| ex_zext | input | 1 | Zero-extend load result |
| ex_byte_addr | input | 32 | Byte address of the access |
| ex_wdata | input | 32 | Store data, right-aligned |
| ex_busy | output | 1 | Pipeline stall request |
| fault_misaligned | output | 1 | Misaligned access refused |
| fault_access | output | 1 | Out-of-range access refused |
| bus_addr | output | ADDR_W | Word address |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_wait | input | 1 | Bus not ready to accept request |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data word |
| ld_valid | output | 1 | Aligned load result valid |
| ld_data | output | 32 | Aligned, extended load result |

## Verification
The bench builds the unit with ADDR_W set to 10, so the legal space ends at byte address 0xFFC. Both the last legal word and the first out-of-range address, 0x1000, can then be reached with short constants. The bench combines an out-of-range address with a misaligned offset to check which fault is reported. It drives loads through zero and several cycles of bus wait and read latency, so the held request and the stall are checked on both sides of acceptance.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned LANES = XLEN / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    acc_size_e  size;
    logic       zext;
    logic [1:0] lane;
  } ld_meta_t;
endpackage

// File: rtl/lsu_req_check.sv
module lsu_req_check
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              valid,
  input  acc_size_e         size,
  input  logic [XLEN-1:0]   byte_addr,
  output logic              mis,
  output logic              acc,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int unsigned TOP = ADDR_W + 2;

  logic odd_off;
  logic range_hit;

  assign word_addr = byte_addr[TOP-1:2];

  always_comb begin
    unique case (size)
      SZ_BYTE: odd_off = 1'b0;
      SZ_HALF: odd_off = byte_addr[0];
      default: odd_off = |byte_addr[1:0];
    endcase
  end

  generate
    if (TOP >= XLEN) begin : g_full
      assign range_hit = 1'b0;
    end else begin : g_limited
      assign range_hit = |byte_addr[XLEN-1:TOP];
    end
  endgenerate

  // misaligned wins over out-of-range (R5)
  assign mis = valid & odd_off;
  assign acc = valid & ~odd_off & range_hit;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic [1:0]       lane,
  input  logic [XLEN-1:0]  wdata,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  data
);
  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        be   = 4'b0001 << lane;
        data = {LANES{wdata[7:0]}};
      end
      SZ_HALF: begin
        be   = 4'b0011 << {lane[1], 1'b0};
        data = {(LANES/2){wdata[15:0]}};
      end
      default: begin
        be   = '1;
        data = wdata;
      end
    endcase
  end

  // R2: lane count follows the access size
  always_comb begin
    if (!$isunknown(size) && !$isunknown(lane)) begin
      assert_lane_count_R2: assert ((size == SZ_BYTE) ? ($countones(be) == 1) :
                                    (size == SZ_HALF) ? ($countones(be) == 2) :
                                                        ($countones(be) == 4));
    end
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  ld_meta_t        meta,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] data
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  assign byte_sel = rdata[{meta.lane, 3'b000} +: 8];
  assign half_sel = meta.lane[1] ? rdata[31:16] : rdata[15:0];

  always_comb begin
    unique case (meta.size)
      SZ_BYTE: data = {{(XLEN-8){byte_sel[7] & ~meta.zext}}, byte_sel};
      SZ_HALF: data = {{(XLEN-16){half_sel[15] & ~meta.zext}}, half_sel};
      default: data = rdata;
    endcase
  end

  // R9: unsigned narrow loads leave the upper bits clear
  always_comb begin
    if (!$isunknown(meta)) begin
      assert_zext_upper_R9: assert (!(meta.zext && meta.size == SZ_BYTE) || data[XLEN-1:8] == '0);
    end
  end
endmodule

// File: rtl/lsu_mem_port.sv
module lsu_mem_port
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  input  logic              ex_store,
  input  logic [1:0]        ex_size,
  input  logic              ex_zext,
  input  logic [31:0]       ex_byte_addr,
  input  logic [31:0]       ex_wdata,
  output logic              ex_busy,
  output logic              fault_misaligned,
  output logic              fault_access,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_write,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  input  logic              bus_wait,
  input  logic              bus_rvalid,
  input  logic [31:0]       bus_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  acc_size_e size;
  logic      mis, acc, fault;
  logic      data_wait, issue, accept_ld;
  logic      pend_q, pend_d;
  ld_meta_t  meta_q, meta_d;
  logic      meta_en;

  assign size = acc_size_e'(ex_size);

  lsu_req_check #(.ADDR_W(ADDR_W)) u_check (
    .valid     (ex_valid),
    .size      (size),
    .byte_addr (ex_byte_addr),
    .mis       (mis),
    .acc       (acc),
    .word_addr (bus_addr)
  );

  lsu_store_lanes u_lanes (
    .size  (size),
    .lane  (ex_byte_addr[1:0]),
    .wdata (ex_wdata),
    .be    (bus_be),
    .data  (bus_wdata)
  );

  assign fault            = mis | acc;
  assign fault_misaligned = mis;
  assign fault_access     = acc;

  assign data_wait = pend_q & ~bus_rvalid;
  assign issue     = ex_valid & ~fault & ~data_wait;
  assign bus_read  = issue & ~ex_store;
  assign bus_write = issue & ex_store;
  assign accept_ld = bus_read & ~bus_wait;
  assign ex_busy   = data_wait | (issue & bus_wait);

  // next-state
  always_comb begin
    pend_d = pend_q;
    if (accept_ld)       pend_d = 1'b1;
    else if (bus_rvalid) pend_d = 1'b0;
    meta_en = accept_ld;
    meta_d  = '{size: size, zext: ex_zext, lane: ex_byte_addr[1:0]};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       meta_q <= '{size: SZ_WORD, zext: 1'b0, lane: 2'b00};
    else if (meta_en) meta_q <= meta_d;
  end

  assign ld_valid = pend_q & bus_rvalid;

  lsu_load_align u_align (
    .meta  (meta_q),
    .rdata (bus_rdata),
    .data  (ld_data)
  );

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

  assert_fault_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_misaligned || fault_access) |-> !(bus_read || bus_write));

  assert_single_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_misaligned && fault_access));

  assert_hold_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_read || bus_write) && bus_wait) |-> ex_busy);

  assert_await_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && !bus_wait) |=> (ex_busy || ld_valid));

  assert_no_stray_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> bus_rvalid);
endmodule

// File: tb/lsu_mem_port_tb.sv
`timescale 1ns/1ps
module lsu_mem_port_tb;
  localparam int unsigned AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ex_valid, ex_store, ex_zext;
  logic [1:0]    ex_size;
  logic [31:0]   ex_byte_addr, ex_wdata;
  logic          ex_busy, fault_misaligned, fault_access;
  logic [AW-1:0] bus_addr;
  logic          bus_read, bus_write;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata;
  logic          bus_wait, bus_rvalid;
  logic [31:0]   bus_rdata;
  logic          ld_valid;
  logic [31:0]   ld_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  lsu_mem_port #(.ADDR_W(AW)) u_dut (
    .clk, .rst_n, .ex_valid, .ex_store, .ex_size, .ex_zext, .ex_byte_addr,
    .ex_wdata, .ex_busy, .fault_misaligned, .fault_access, .bus_addr,
    .bus_read, .bus_write, .bus_be, .bus_wdata, .bus_wait, .bus_rvalid,
    .bus_rdata, .ld_valid, .ld_data
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] wexp;
    logic        mis;
    logic        acc;
  } svec_t;

  localparam svec_t SV [0:9] = '{
    '{2'd0, 32'h0000_0101, 32'h0000_00A5, 4'b0010, 32'hA5A5_A5A5, 1'b0, 1'b0},
    '{2'd0, 32'h0000_0103, 32'h1234_5677, 4'b1000, 32'h7777_7777, 1'b0, 1'b0},
    '{2'd1, 32'h0000_0202, 32'h0000_BEEF, 4'b1100, 32'hBEEF_BEEF, 1'b0, 1'b0},
    '{2'd1, 32'h0000_0200, 32'h1111_2222, 4'b0011, 32'h2222_2222, 1'b0, 1'b0},
    '{2'd2, 32'h0000_0FFC, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, 1'b0, 1'b0},
    '{2'd3, 32'h0000_0010, 32'h0BAD_BEEF, 4'b1111, 32'h0BAD_BEEF, 1'b0, 1'b0},
    '{2'd2, 32'h0000_1000, 32'h0,         4'b0000, 32'h0,         1'b0, 1'b1},
    '{2'd1, 32'h0000_0201, 32'h0,         4'b0000, 32'h0,         1'b1, 1'b0},
    '{2'd2, 32'h0000_1002, 32'h0,         4'b0000, 32'h0,         1'b1, 1'b0},
    '{2'd0, 32'h8000_0003, 32'h0,         4'b0000, 32'h0,         1'b0, 1'b1}
  };

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic do_load(input logic [1:0] sz, input logic zx, input logic [31:0] addr,
                         input logic [31:0] rd, input logic [31:0] exp,
                         input int waits, input int lat, input string tag);
    ex_valid = 1; ex_store = 0; ex_size = sz; ex_zext = zx; ex_byte_addr = addr;
    bus_wait = (waits > 0);
    for (int i = 0; i < waits; i++) begin
      #1;
      chk(bus_read && ex_busy, "R6 held read", {30'd0, bus_read, ex_busy}, 32'h3);
      @(negedge clk);
    end
    bus_wait = 0;
    #1;
    chk(bus_read && bus_addr == addr[AW+1:2], "R1 read word addr", {{(32-AW){1'b0}}, bus_addr}, {22'd0, addr[AW+1:2]});
    @(negedge clk);
    ex_valid = 0;
    for (int j = 0; j < lat; j++) begin
      #1;
      chk(ex_busy && !ld_valid, "R7 awaiting data", {30'd0, ex_busy, ld_valid}, 32'h2);
      @(negedge clk);
    end
    bus_rvalid = 1; bus_rdata = rd;
    #1;
    chk(ld_valid && !ex_busy, "R7 data return", {30'd0, ld_valid, ex_busy}, 32'h2);
    chk(ld_data == exp, tag, ld_data, exp);
    @(negedge clk);
    bus_rvalid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; ex_valid = 0; ex_store = 0; ex_size = 0; ex_zext = 0;
    ex_byte_addr = 0; ex_wdata = 0; bus_wait = 0; bus_rvalid = 0; bus_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!ex_busy && !ld_valid && !bus_read && !bus_write && !fault_misaligned && !fault_access,
        "R10 reset idle", {26'd0, ex_busy, ld_valid, bus_read, bus_write, fault_misaligned, fault_access}, 32'h0);
    @(negedge clk);

    // store and fault table
    for (int k = 0; k < 10; k++) begin
      ex_valid = 1; ex_store = 1; ex_size = SV[k].sz; ex_zext = 0;
      ex_byte_addr = SV[k].addr; ex_wdata = SV[k].wd;
      #1;
      chk(fault_misaligned == SV[k].mis, "R4 misaligned flag", {31'd0, fault_misaligned}, {31'd0, SV[k].mis});
      chk(fault_access == SV[k].acc, "R5 access flag", {31'd0, fault_access}, {31'd0, SV[k].acc});
      if (SV[k].mis || SV[k].acc) begin
        chk(!bus_write && !bus_read, "R4 R5 no strobe", {30'd0, bus_read, bus_write}, 32'h0);
      end else begin
        chk(bus_write && !bus_read, "R1 write strobe", {30'd0, bus_read, bus_write}, 32'h1);
        chk(bus_addr == SV[k].addr[AW+1:2], "R1 word addr", {22'd0, bus_addr}, {22'd0, SV[k].addr[AW+1:2]});
        chk(bus_be == SV[k].be, "R2 byte enables", {28'd0, bus_be}, {28'd0, SV[k].be});
        chk(bus_wdata == SV[k].wexp, "R3 store data", bus_wdata, SV[k].wexp);
      end
      @(negedge clk);
    end
    ex_valid = 0;

    // store held under wait
    ex_valid = 1; ex_store = 1; ex_size = 2'd2; ex_byte_addr = 32'h40; ex_wdata = 32'h1;
    bus_wait = 1;
    #1;
    chk(bus_write && ex_busy, "R6 held write", {30'd0, bus_write, ex_busy}, 32'h3);
    @(negedge clk);
    #1;
    chk(bus_write && ex_busy && bus_addr == 10'h010, "R6 write still held", {30'd0, bus_write, ex_busy}, 32'h3);
    @(negedge clk);
    bus_wait = 0;
    #1;
    chk(!ex_busy, "R6 release", {31'd0, ex_busy}, 32'h0);
    @(negedge clk);
    ex_valid = 0;

    // loads
    do_load(2'd0, 0, 32'h100, 32'h8091_A2F3, 32'hFFFF_FFF3, 0, 0, "R8 LB lane0");
    do_load(2'd0, 1, 32'h101, 32'h8091_A2F3, 32'h0000_00A2, 2, 1, "R9 LBU lane1");
    do_load(2'd0, 0, 32'h102, 32'h8091_A2F3, 32'hFFFF_FF91, 0, 3, "R8 LB lane2");
    do_load(2'd0, 0, 32'h103, 32'h8091_A2F3, 32'hFFFF_FF80, 1, 0, "R8 LB lane3");
    do_load(2'd1, 0, 32'h202, 32'h8091_A2F3, 32'hFFFF_8091, 0, 2, "R8 LH upper");
    do_load(2'd1, 1, 32'h200, 32'h8091_A2F3, 32'h0000_A2F3, 3, 0, "R9 LHU lower");
    do_load(2'd1, 0, 32'h204, 32'h0000_7FFF, 32'h0000_7FFF, 0, 0, "R8 LH positive");
    do_load(2'd2, 0, 32'hFFC, 32'h8091_A2F3, 32'h8091_A2F3, 1, 4, "R8 LW");

    // stray read-data-valid
    bus_rvalid = 1; bus_rdata = 32'hDEAD_BEEF;
    #1;
    chk(!ld_valid && !ex_busy, "R11 stray rvalid", {30'd0, ld_valid, ex_busy}, 32'h0);
    @(negedge clk);
    bus_rvalid = 0;

    // faulting load: no read, no stall
    ex_valid = 1; ex_store = 0; ex_size = 2'd2; ex_byte_addr = 32'h0000_2000;
    #1;
    chk(fault_access && !bus_read && !ex_busy, "R5 faulting load", {29'd0, fault_access, bus_read, ex_busy}, 32'h4);
    @(negedge clk);
    ex_valid = 0;
    @(negedge clk);
    #1;
    chk(!ex_busy && !ld_valid, "R11 no pending after fault", {30'd0, ex_busy, ld_valid}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule